// File: doc/BRIEF.md
# Runahead Retirement Controller

This block sits beside the reorder buffer of a small out-of-order core and decides when the core leaves normal execution for runahead execution, and when it comes back. It looks at the oldest entry of the instruction window every cycle. In normal mode it retires completed instructions into the register file. When the oldest entry is a load that is still waiting on a long-latency miss, it copies the whole register file into a checkpoint, records that load's PC, and switches to runahead mode.

In runahead mode the block pseudo-retires the oldest entry. It keeps one poison bit per register to mark values that depend on the missing data. An entry is poisoned when it is itself a miss load or when either of its source registers is poisoned. A poisoned entry leaves the window at once and poisons its destination. A clean entry leaves only after it completes, and it writes its value into the working register file. Branches whose operands are clean are resolved, and a mispredicted one raises a recovery redirect. Branches that read a poisoned operand stay on the predicted path.

When the miss data returns, the block restores the checkpoint, clears every poison bit, and holds retirement back. In the next cycle it pulses a pipeline flush that redirects fetch to the PC of the load that caused the episode. A registered read port lets the execution side read register values and poison bits.

Top module: `runahead_ctl`

## Requirements
- R1: After reset the block is in normal mode, `flush` and `rcv_vld` are low, and every register reads as zero with a clear poison bit.
- R2: In normal mode, a valid head with `hd_miss` set does not pop. `ra_mode` is high from the next cycle, and the current register contents become the checkpoint.
- R3: In normal mode, `ret_pop` is high exactly when the head is valid, has `hd_done` set and has `hd_miss` clear. A popped entry with `hd_wen` set writes `hd_res` to register `hd_dst`.
- R4: In runahead mode, a valid head is poisoned when `hd_miss` is set or when the poison bit of `hd_src_a` or `hd_src_b` is set. A poisoned head pops in the same cycle whatever `hd_done` is. With `hd_wen` set, it sets the poison bit of `hd_dst` and leaves that register's value unchanged.
- R5: In runahead mode, a clean head pops only when `hd_done` is set. With `hd_wen` set, it writes `hd_res` into the working register and clears that register's poison bit.
- R6: A miss at the head during runahead mode starts no new episode and takes no new checkpoint. It is handled as a poisoned head. The later exit still restores the first checkpoint and redirects to the first trigger PC.
- R7: `miss_ret` in runahead mode restores all registers to the checkpoint and clears all poison bits on that clock edge. In the following cycle `flush` is high for exactly one cycle with `flush_pc` equal to the trigger load's PC, and `ra_mode` is low.
- R8: `ret_pop` stays low in the cycle `miss_ret` is taken and in the cycle `flush` is high.
- R9: `miss_ret` outside runahead mode has no effect: no flush, no mode change.
- R10: A branch with `br_vld` and `br_mispred` set, whose two operand registers both have clear poison bits, raises `rcv_vld` in the next cycle with `rcv_pc` equal to `br_target`. A branch with either operand poisoned raises nothing. No recovery is raised for a branch presented in the `miss_ret` cycle or the flush cycle.
- R11: `rd_data` and `rd_inv` give, one cycle after `rd_addr` is presented, the value and poison bit of that register as they stood before that cycle's updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hd_vld | input | 1 | Oldest window entry is valid |
| hd_miss | input | 1 | Oldest entry is a load waiting on a long-latency miss |
| hd_done | input | 1 | Oldest entry has finished execution |
| hd_pc | input | PC_W | PC of the oldest entry |
| hd_wen | input | 1 | Oldest entry writes a destination register |
| hd_dst | input | AW | Destination register of the oldest entry |
| hd_src_a | input | AW | First source register of the oldest entry |
| hd_src_b | input | AW | Second source register of the oldest entry |
| hd_res | input | DW | Result value of the oldest entry |
| ret_pop | output | 1 | Remove the oldest entry this cycle |
| miss_ret | input | 1 | Data of the triggering miss has returned |
| br_vld | input | 1 | A branch is resolving this cycle |
| br_src_a | input | AW | First operand register of the branch |
| br_src_b | input | AW | Second operand register of the branch |
| br_mispred | input | 1 | The branch outcome differs from the prediction |
| br_target | input | PC_W | Correct target of the branch |
| rcv_vld | output | 1 | Branch recovery redirect |
| rcv_pc | output | PC_W | Redirect PC for branch recovery |
| flush | output | 1 | One-cycle pipeline flush on runahead exit |
| flush_pc | output | PC_W | Restart PC after the flush |
| ra_mode | output | 1 | Block is in runahead mode |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register value, one cycle after the address |
| rd_inv | output | 1 | Poison bit, one cycle after the address |

## Verification
Every cycle, the assertions check these rules. The flush lasts one cycle and only follows a miss return taken in runahead mode. Nothing pops during the restore and flush cycles. In normal mode, nothing pops unless it is complete and not a miss. A miss head in runahead mode is always drained. Entry follows a miss head in normal mode. A recovery always traces back to a mispredicted branch. Other properties need data and span a whole episode, so only the bench scenarios can show them. These are: the restored register values after exit, poison spreading through chains of dependent instructions, the survival of the first trigger PC across a nested miss, and the suppression of recoveries for poisoned branch operands.

// File: rtl/ra_pkg.sv
package ra_pkg;
  typedef enum logic [1:0] {
    RA_NORM  = 2'd0,
    RA_RUN   = 2'd1,
    RA_RECOV = 2'd2
  } ra_state_e;
endpackage

// File: rtl/ra_regfile.sv
// Working register file with a full-width shadow copy taken on entry
// and copied back in a single edge on exit.
module ra_regfile #(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          snap,
  input  logic          restore,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] live [NREG];
  logic [DW-1:0] shadow [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        live[i]   <= '0;
        shadow[i] <= '0;
      end
      rd_data <= '0;
    end else begin
      rd_data <= live[rd_addr];
      for (int i = 0; i < NREG; i++) begin
        if (restore) begin
          live[i] <= shadow[i];
        end else if (wr_en && (wr_idx == AW'(i))) begin
          live[i] <= wr_data;
        end
        if (snap) begin
          shadow[i] <= live[i];
        end
      end
    end
  end
endmodule

// File: rtl/ra_inv_track.sv
// One poison bit per register with several combinational lookup ports
// and a registered read port.
module ra_inv_track #(
  parameter int NREG  = 16,
  parameter int NLOOK = 4,
  parameter int AW    = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr_all,
  input  logic                       set_en,
  input  logic [AW-1:0]              set_idx,
  input  logic                       set_val,
  input  logic [NLOOK-1:0][AW-1:0]   look_idx,
  output logic [NLOOK-1:0]           look_inv,
  input  logic [AW-1:0]              rd_addr,
  output logic                       rd_inv
);
  logic [NREG-1:0] inv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      inv_q  <= '0;
      rd_inv <= 1'b0;
    end else begin
      rd_inv <= inv_q[rd_addr];
      if (clr_all) begin
        inv_q <= '0;
      end else if (set_en) begin
        inv_q[set_idx] <= set_val;
      end
    end
  end

  for (genvar k = 0; k < NLOOK; k++) begin : g_look
    assign look_inv[k] = inv_q[look_idx[k]];
  end
endmodule

// File: rtl/ra_mode_fsm.sv
// Mode sequencing: normal -> runahead -> one recover cycle -> normal.
module ra_mode_fsm
  import ra_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter,
  input  logic            restore,
  input  logic [PC_W-1:0] trig_pc_in,
  output ra_state_e       state,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc
);
  ra_state_e       state_q;
  logic [PC_W-1:0] trig_pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= RA_NORM;
      trig_pc_q <= '0;
      flush     <= 1'b0;
      flush_pc  <= '0;
    end else begin
      flush <= 1'b0;
      unique case (state_q)
        RA_NORM: begin
          if (enter) begin
            state_q   <= RA_RUN;
            trig_pc_q <= trig_pc_in;
          end
        end
        RA_RUN: begin
          if (restore) begin
            state_q  <= RA_RECOV;
            flush    <= 1'b1;
            flush_pc <= trig_pc_q;
          end
        end
        default: begin
          state_q <= RA_NORM;
        end
      endcase
    end
  end

  assign state = state_q;
endmodule

// File: rtl/runahead_ctl.sv
module runahead_ctl
  import ra_pkg::*;
#(
  parameter int NREG = 16,
  parameter int DW   = 32,
  parameter int PC_W = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hd_vld,
  input  logic            hd_miss,
  input  logic            hd_done,
  input  logic [PC_W-1:0] hd_pc,
  input  logic            hd_wen,
  input  logic [AW-1:0]   hd_dst,
  input  logic [AW-1:0]   hd_src_a,
  input  logic [AW-1:0]   hd_src_b,
  input  logic [DW-1:0]   hd_res,
  output logic            ret_pop,
  input  logic            miss_ret,
  input  logic            br_vld,
  input  logic [AW-1:0]   br_src_a,
  input  logic [AW-1:0]   br_src_b,
  input  logic            br_mispred,
  input  logic [PC_W-1:0] br_target,
  output logic            rcv_vld,
  output logic [PC_W-1:0] rcv_pc,
  output logic            flush,
  output logic [PC_W-1:0] flush_pc,
  output logic            ra_mode,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic            rd_inv
);
  localparam int NLOOK = 4;

  ra_state_e             state;
  logic [NLOOK-1:0][AW-1:0] look_idx;
  logic [NLOOK-1:0]      look_inv;
  logic                  head_inv;
  logic                  br_inv;
  logic                  enter;
  logic                  restore;
  logic                  rf_wen;
  logic                  inv_set;

  assign look_idx[0] = hd_src_a;
  assign look_idx[1] = hd_src_b;
  assign look_idx[2] = br_src_a;
  assign look_idx[3] = br_src_b;

  assign head_inv = hd_miss | look_inv[0] | look_inv[1];
  assign br_inv   = look_inv[2] | look_inv[3];

  // Retirement decision per mode
  always_comb begin
    enter   = 1'b0;
    restore = 1'b0;
    ret_pop = 1'b0;
    rf_wen  = 1'b0;
    inv_set = 1'b0;
    unique case (state)
      RA_NORM: begin
        enter   = hd_vld & hd_miss;
        ret_pop = hd_vld & hd_done & ~hd_miss;
        rf_wen  = ret_pop & hd_wen;
      end
      RA_RUN: begin
        restore = miss_ret;
        ret_pop = hd_vld & ~miss_ret & (head_inv | hd_done);
        inv_set = ret_pop & hd_wen;
        rf_wen  = ret_pop & hd_wen & ~head_inv;
      end
      default: begin
        ret_pop = 1'b0;
      end
    endcase
  end

  ra_mode_fsm #(.PC_W(PC_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .enter      (enter),
    .restore    (restore),
    .trig_pc_in (hd_pc),
    .state      (state),
    .flush      (flush),
    .flush_pc   (flush_pc)
  );

  ra_regfile #(.NREG(NREG), .DW(DW), .AW(AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rf_wen),
    .wr_idx  (hd_dst),
    .wr_data (hd_res),
    .snap    (enter),
    .restore (restore),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  ra_inv_track #(.NREG(NREG), .NLOOK(NLOOK), .AW(AW)) u_inv (
    .clk      (clk),
    .rst      (rst),
    .clr_all  (restore),
    .set_en   (inv_set),
    .set_idx  (hd_dst),
    .set_val  (head_inv),
    .look_idx (look_idx),
    .look_inv (look_inv),
    .rd_addr  (rd_addr),
    .rd_inv   (rd_inv)
  );

  // Branch recovery, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      rcv_vld <= 1'b0;
      rcv_pc  <= '0;
    end else begin
      rcv_vld <= 1'b0;
      if (br_vld && br_mispred && !br_inv && (state != RA_RECOV) && !restore) begin
        rcv_vld <= 1'b1;
        rcv_pc  <= br_target;
      end
    end
  end

  assign ra_mode = (state == RA_RUN);
endmodule

// File: rtl/runahead_ctl_chk.sv
module runahead_ctl_chk (
  input logic clk,
  input logic rst,
  input logic hd_vld,
  input logic hd_miss,
  input logic hd_done,
  input logic miss_ret,
  input logic br_vld,
  input logic br_mispred,
  input logic ret_pop,
  input logic ra_mode,
  input logic flush,
  input logic rcv_vld
);
  // R7
  flush_single_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !flush);

  // R7
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> $past(miss_ret && ra_mode));

  // R8
  no_pop_restore_chk: assert property (@(posedge clk) disable iff (rst)
    (flush || (ra_mode && miss_ret)) |-> !ret_pop);

  // R3
  normal_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (!ra_mode && ret_pop) |-> (hd_vld && hd_done && !hd_miss));

  // R4
  inv_drain_chk: assert property (@(posedge clk) disable iff (rst)
    (ra_mode && !miss_ret && hd_vld && hd_miss) |-> ret_pop);

  // R2
  enter_chk: assert property (@(posedge clk) disable iff (rst)
    (!ra_mode && !flush && hd_vld && hd_miss) |=> ra_mode);

  // R10
  rcv_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rcv_vld |-> $past(br_vld && br_mispred));
endmodule

bind runahead_ctl runahead_ctl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .hd_vld     (hd_vld),
  .hd_miss    (hd_miss),
  .hd_done    (hd_done),
  .miss_ret   (miss_ret),
  .br_vld     (br_vld),
  .br_mispred (br_mispred),
  .ret_pop    (ret_pop),
  .ra_mode    (ra_mode),
  .flush      (flush),
  .rcv_vld    (rcv_vld)
);

// File: tb/tb_runahead_ctl.sv
module tb_runahead_ctl;
  localparam int NREG = 16;
  localparam int DW   = 32;
  localparam int PC_W = 32;
  localparam int AW   = $clog2(NREG);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hd_vld, hd_miss, hd_done, hd_wen, miss_ret, br_vld, br_mispred;
  logic [PC_W-1:0] hd_pc, br_target;
  logic [AW-1:0] hd_dst, hd_src_a, hd_src_b, br_src_a, br_src_b, rd_addr;
  logic [DW-1:0] hd_res;
  logic ret_pop, rcv_vld, flush, ra_mode, rd_inv;
  logic [PC_W-1:0] rcv_pc, flush_pc;
  logic [DW-1:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic [DW-1:0] m_live [NREG];
  logic [DW-1:0] m_ckpt [NREG];
  bit            m_inv  [NREG];
  int            m_st;  // 0 normal, 1 runahead, 2 recover
  logic [PC_W-1:0] m_trig;

  always #5 clk = ~clk;

  runahead_ctl #(.NREG(NREG), .DW(DW), .PC_W(PC_W)) dut (
    .clk(clk), .rst(rst),
    .hd_vld(hd_vld), .hd_miss(hd_miss), .hd_done(hd_done), .hd_pc(hd_pc),
    .hd_wen(hd_wen), .hd_dst(hd_dst), .hd_src_a(hd_src_a), .hd_src_b(hd_src_b),
    .hd_res(hd_res), .ret_pop(ret_pop), .miss_ret(miss_ret),
    .br_vld(br_vld), .br_src_a(br_src_a), .br_src_b(br_src_b),
    .br_mispred(br_mispred), .br_target(br_target),
    .rcv_vld(rcv_vld), .rcv_pc(rcv_pc), .flush(flush), .flush_pc(flush_pc),
    .ra_mode(ra_mode), .rd_addr(rd_addr), .rd_data(rd_data), .rd_inv(rd_inv)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    hd_vld = 0; hd_miss = 0; hd_done = 0; hd_pc = '0; hd_wen = 0;
    hd_dst = '0; hd_src_a = '0; hd_src_b = '0; hd_res = '0;
    miss_ret = 0; br_vld = 0; br_src_a = '0; br_src_b = '0;
    br_mispred = 0; br_target = '0; rd_addr = '0;
  endtask

  task automatic head(input bit miss, input bit done, input logic [PC_W-1:0] pc,
                      input bit wen, input int dst, input int sa, input int sb,
                      input logic [DW-1:0] res);
    hd_vld = 1; hd_miss = miss; hd_done = done; hd_pc = pc; hd_wen = wen;
    hd_dst = AW'(dst); hd_src_a = AW'(sa); hd_src_b = AW'(sb); hd_res = res;
  endtask

  // One clock cycle: inputs already driven; checks pop, then registered outputs.
  task automatic cycle();
    bit hinv, pop_e, enter_e, restore_e, binv, rcv_e, rdinv_e;
    logic [DW-1:0] rd_e;
    logic [PC_W-1:0] fpc_e;
    string ptag, ftag;
    int st0;
    #1;
    st0 = m_st;
    hinv = hd_miss | m_inv[hd_src_a] | m_inv[hd_src_b];
    enter_e = 0; restore_e = 0;
    case (m_st)
      0: begin pop_e = hd_vld && hd_done && !hd_miss; enter_e = hd_vld && hd_miss; ptag = "R3"; end
      1: begin
        restore_e = miss_ret;
        pop_e = hd_vld && !miss_ret && (hinv || hd_done);
        ptag = miss_ret ? "R8" : (hinv ? "R4" : "R5");
      end
      default: begin pop_e = 0; ptag = "R8"; end
    endcase
    chk(ret_pop === pop_e, ptag, "ret_pop", 64'(ret_pop), 64'(pop_e));
    rd_e = m_live[rd_addr];
    rdinv_e = m_inv[rd_addr];
    binv = m_inv[br_src_a] | m_inv[br_src_b];
    rcv_e = br_vld && br_mispred && !binv && (m_st != 2) && !restore_e;
    fpc_e = m_trig;
    ftag = (miss_ret && st0 != 1) ? "R9" : "R7";
    // model update
    case (m_st)
      0: begin
        if (enter_e) begin
          for (int i = 0; i < NREG; i++) m_ckpt[i] = m_live[i];
          m_trig = hd_pc;
          m_st = 1;
        end else if (pop_e && hd_wen) begin
          m_live[hd_dst] = hd_res;
        end
      end
      1: begin
        if (restore_e) begin
          for (int i = 0; i < NREG; i++) begin m_live[i] = m_ckpt[i]; m_inv[i] = 0; end
          m_st = 2;
        end else if (pop_e && hd_wen) begin
          m_inv[hd_dst] = hinv;
          if (!hinv) m_live[hd_dst] = hd_res;
        end
      end
      default: m_st = 0;
    endcase
    @(posedge clk);
    #1;
    chk(flush === restore_e, ftag, "flush", 64'(flush), 64'(restore_e));
    if (restore_e) chk(flush_pc === fpc_e, "R7", "flush_pc", 64'(flush_pc), 64'(fpc_e));
    chk(rcv_vld === rcv_e, "R10", "rcv_vld", 64'(rcv_vld), 64'(rcv_e));
    if (rcv_e) chk(rcv_pc === br_target, "R10", "rcv_pc", 64'(rcv_pc), 64'(br_target));
    chk(ra_mode === (m_st == 1), "R2", "ra_mode", 64'(ra_mode), 64'(m_st == 1));
    chk(rd_data === rd_e, "R11", "rd_data", 64'(rd_data), 64'(rd_e));
    chk(rd_inv === rdinv_e, "R11", "rd_inv", 64'(rd_inv), 64'(rdinv_e));
  endtask

  task automatic rand_inputs();
    int unsigned r;
    idle();
    r = $urandom_range(0, 99);
    hd_vld  = (r < 80);
    hd_miss = (m_st == 1) ? ($urandom_range(0, 11) == 0) : ($urandom_range(0, 7) == 0);
    hd_done = $urandom_range(0, 1) == 1;
    hd_pc   = PC_W'($urandom);
    hd_wen  = $urandom_range(0, 3) != 0;
    hd_dst  = AW'($urandom_range(0, NREG - 1));
    hd_src_a = AW'($urandom_range(0, NREG - 1));
    hd_src_b = AW'($urandom_range(0, NREG - 1));
    hd_res  = DW'($urandom);
    miss_ret = (m_st == 1) ? ($urandom_range(0, 13) == 0) : ($urandom_range(0, 39) == 0);
    br_vld  = $urandom_range(0, 2) == 0;
    br_src_a = AW'($urandom_range(0, NREG - 1));
    br_src_b = AW'($urandom_range(0, NREG - 1));
    br_mispred = $urandom_range(0, 1) == 1;
    br_target = PC_W'($urandom);
    rd_addr = AW'($urandom_range(0, NREG - 1));
  endtask

  initial begin
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1A2B3C4D);
    for (int i = 0; i < NREG; i++) begin m_live[i] = '0; m_ckpt[i] = '0; m_inv[i] = 0; end
    m_st = 0;
    m_trig = '0;
    idle();
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1: reset state
    chk(ra_mode === 1'b0, "R1", "ra_mode", 64'(ra_mode), 0);
    chk(flush === 1'b0, "R1", "flush", 64'(flush), 0);
    chk(rcv_vld === 1'b0, "R1", "rcv_vld", 64'(rcv_vld), 0);
    chk(rd_data === '0, "R1", "rd_data", 64'(rd_data), 0);
    chk(rd_inv === 1'b0, "R1", "rd_inv", 64'(rd_inv), 0);

    // R3: normal retirement writes r3
    idle(); head(0, 1, 32'h40, 1, 3, 0, 0, 32'hAAAA); cycle();
    // R2: miss at head enters runahead
    idle(); head(1, 0, 32'h100, 1, 5, 1, 2, 32'h0); cycle();
    chk(ra_mode === 1'b1, "R2", "ra_mode after entry", 64'(ra_mode), 1);
    // R4: trigger load drains as poisoned
    idle(); head(1, 0, 32'h100, 1, 5, 1, 2, 32'h0); cycle();
    // R4: dependent of r5 drains without completing
    idle(); head(0, 0, 32'h104, 1, 6, 5, 0, 32'h1234); cycle();
    // R5: clean head waits, then writes working value
    idle(); head(0, 0, 32'h108, 1, 3, 3, 3, 32'hBBBB); cycle();
    idle(); head(0, 1, 32'h108, 1, 3, 3, 3, 32'hBBBB); cycle();
    // R6: second miss is poisoned, no new episode
    idle(); head(1, 0, 32'h200, 1, 7, 0, 0, 32'h0); cycle();
    chk(ra_mode === 1'b1, "R6", "ra_mode after nested miss", 64'(ra_mode), 1);
    // R10: branch on poisoned r6 is not resolved
    idle(); br_vld = 1; br_mispred = 1; br_src_a = 6; br_target = 32'h300; cycle();
    chk(rcv_vld === 1'b0, "R10", "rcv on poisoned operand", 64'(rcv_vld), 0);
    idle(); br_vld = 1; br_mispred = 1; br_src_a = 3; br_src_b = 0; br_target = 32'h340; cycle();
    // R11: working value visible
    idle(); rd_addr = 3; cycle();
    chk(rd_data === 32'hBBBB, "R11", "working r3", 64'(rd_data), 64'h BBBB);
    // R7: miss returns
    idle(); miss_ret = 1; head(0, 1, 32'h10C, 1, 4, 0, 0, 32'h5); cycle();
    chk(flush_pc === 32'h100, "R6", "flush_pc first trigger", 64'(flush_pc), 64'h100);
    // R8: no pop in flush cycle; read restored r3
    idle(); head(0, 1, 32'h100, 1, 4, 0, 0, 32'h7); rd_addr = 3; cycle();
    chk(rd_data === 32'hAAAA, "R7", "restored r3", 64'(rd_data), 64'hAAAA);
    idle(); rd_addr = 6; cycle();
    chk(rd_inv === 1'b0, "R7", "poison cleared r6", 64'(rd_inv), 0);
    // R9: stray miss return in normal mode
    idle(); miss_ret = 1; cycle();
    chk(flush === 1'b0, "R9", "flush in normal mode", 64'(flush), 0);
    chk(ra_mode === 1'b0, "R9", "ra_mode in normal mode", 64'(ra_mode), 0);

    // constrained random phase
    for (int n = 0; n < 4000; n++) begin
      rand_inputs();
      cycle();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule